// File: doc/BRIEF.md
# Local Request Front End for an SDRAM Command Scheduler

This block sits between a user-side bus master and a simplified SDRAM command scheduler. The master presents read or write requests on a burst-oriented memory-mapped port. Each request carries an address, a binary beat count, write data, an auto-precharge flag and a one-cycle burst-start strobe. The master may also raise a user refresh request. The block throttles the master through a `ready` output. It turns every granted request into exactly one command for the scheduler, which it presents on a valid/ready command port.

The burst-start strobe is an event and is not held under back-pressure. The block therefore remembers a strobe that arrives while `ready` is low. Refresh requests are counted in a small saturating counter and win arbitration between accesses. They never interrupt a write burst whose beats are still arriving. Write beats that the block accepts are forwarded on a registered data output. Nothing is accepted, and no command is issued, until the PHY reset input has been released.

Top module: `lreq_frontend`

## Requirements
- R1: While `phy_rst_n` is low, `ready` is low and no request is accepted and no command is issued, even when requests and the burst-start strobe are driven.
- R2: The first beat of a burst is accepted only on a clock edge where a request and `ready` are both high and a burst-start strobe is seen in that cycle or was seen earlier and not yet consumed. A strobe that comes while `ready` is low is remembered. A request without any strobe is never accepted.
- R3: Each accepted access gives one command with `cmd_op` encoded as 1 = read, 2 = write, 3 = read with auto-precharge, 4 = write with auto-precharge, 5 = refresh. A write is chosen when `wr_req` is high and `rd_req` is low. `cmd_addr` and `cmd_beats` carry the request's address and beat count.
- R4: A `size` of 0 gives a 1-beat command and a `size` of 3 or more gives a 2-beat command. Either case sets `size_err`, which stays high until reset.
- R5: When a refresh is pending and no burst is in progress, the refresh command is issued before any waiting read or write, and `ready` stays low until all pending refreshes have been issued.
- R6: For a 2-beat write, the second beat needs no burst-start strobe. It is accepted only after the write command has been taken, and a refresh that arrives in between is issued only after the second beat.
- R7: Refresh requests, one per cycle of `rf_req` high, are counted up to 2^RF_CW-1 (3 by default). Further requests are dropped, and one refresh command is issued per counted request.
- R8: Each accepted write beat appears on `wd_data` with `wd_valid` high for exactly one cycle, on the cycle after the beat is accepted, in beat order.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command holds `cmd_op`, `cmd_addr` and `cmd_beats` stable, and `ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| phy_rst_n | input | 1 | PHY reset, active low; requests are gated until it is high |
| burst_start | input | 1 | One-cycle strobe marking the start of a burst |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| apch_req | input | 1 | Ask for the self-precharging form of the access |
| rf_req | input | 1 | User refresh request, one per cycle high |
| addr | input | AW | Access address |
| size | input | SZW | Binary beat count (legal values 1 and 2) |
| wdata | input | LDW | Write data for the current beat |
| ready | output | 1 | Request port may accept a beat this cycle |
| cmd_valid | output | 1 | Command is presented to the scheduler |
| cmd_ready | input | 1 | Scheduler takes the command |
| cmd_op | output | 3 | Command code |
| cmd_addr | output | AW | Command address |
| cmd_beats | output | 2 | Command beat count (1 or 2) |
| wd_valid | output | 1 | Forwarded write beat valid |
| wd_data | output | LDW | Forwarded write beat data |
| size_err | output | 1 | Sticky flag for an illegal size |

## Verification
The assertions assume that the master keeps a request and its fields steady while `ready` is low, that it never raises `rd_req` and `wr_req` together, and that the scheduler drives `cmd_ready` as a plain per-cycle acceptance. The bench changes request inputs only at the falling edge. It holds every request until the design accepts it, and it lowers the burst-start strobe after its first cycle. Random stimulus varies sizes over the whole `size` range, the auto-precharge flag, the address and data, and the scheduler stalls. It never drives both request lines at once.

// File: rtl/lreq_pkg.sv
package lreq_pkg;

    typedef enum logic [2:0] {
        OP_IDLE = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_RDA  = 3'd3,
        OP_WRA  = 3'd4,
        OP_RFSH = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_WB2  = 2'd2
    } st_e;

endpackage

// File: rtl/lreq_size_norm.sv
module lreq_size_norm #(
    parameter int SZW = 3
) (
    input  logic [SZW-1:0] size,
    output logic [1:0]     beats,
    output logic           bad
);
    localparam logic [SZW-1:0] ONE = SZW'(1);
    localparam logic [SZW-1:0] TWO = SZW'(2);

    always_comb begin
        bad   = (size == '0) || (size > TWO);
        beats = (size >= TWO) ? 2'd2 : 2'd1;
        if (size == ONE) beats = 2'd1;
    end
endmodule

// File: rtl/lreq_rf_count.sv
module lreq_rf_count #(
    parameter int RF_CW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [RF_CW-1:0] cnt,
    output logic             pend
);
    localparam logic [RF_CW-1:0] MAXV = '1;

    logic [RF_CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != MAXV) cnt_d = cnt_q + 1'b1;
        else if (dec && !inc && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt  = cnt_q;
    assign pend = (cnt_q != '0);
endmodule

// File: rtl/lreq_frontend.sv
module lreq_frontend
    import lreq_pkg::*;
#(
    parameter int AW        = 24,
    parameter int MEM_DW    = 16,
    parameter bit HALF_RATE = 1'b0,
    parameter int SZW       = 3,
    parameter int RF_CW     = 2,
    localparam int LDW      = MEM_DW * (HALF_RATE ? 4 : 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           phy_rst_n,
    input  logic           burst_start,
    input  logic           rd_req,
    input  logic           wr_req,
    input  logic           apch_req,
    input  logic           rf_req,
    input  logic [AW-1:0]  addr,
    input  logic [SZW-1:0] size,
    input  logic [LDW-1:0] wdata,
    output logic           ready,
    output logic           cmd_valid,
    input  logic           cmd_ready,
    output logic [2:0]     cmd_op,
    output logic [AW-1:0]  cmd_addr,
    output logic [1:0]     cmd_beats,
    output logic           wd_valid,
    output logic [LDW-1:0] wd_data,
    output logic           size_err
);

    typedef struct packed {
        st_e            st;
        logic           bb;
        op_e            op;
        logic [AW-1:0]  addr;
        logic [1:0]     beats;
        logic [1:0]     cnt;
        logic           wd_valid;
        logic [LDW-1:0] wd_data;
        logic           err;
    } fe_state_t;

    fe_state_t r_q, r_d;

    logic [1:0]       norm_beats;
    logic             norm_bad;
    logic             rf_pend;
    logic             take_rf;
    logic             acc_first;
    logic             acc_next;
    logic [RF_CW-1:0] rf_cnt;

    lreq_size_norm #(.SZW(SZW)) u_norm (
        .size  (size),
        .beats (norm_beats),
        .bad   (norm_bad)
    );

    lreq_rf_count #(.RF_CW(RF_CW)) u_rfc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rf_req),
        .dec   (take_rf),
        .cnt   (rf_cnt),
        .pend  (rf_pend)
    );

    // Request port is open in idle with no refresh owed, or while waiting
    // for the second write beat; never before the PHY is out of reset.
    assign ready = phy_rst_n &&
                   (((r_q.st == ST_IDLE) && !rf_pend) || (r_q.st == ST_WB2));

    always_comb begin
        r_d          = r_q;
        r_d.wd_valid = 1'b0;
        take_rf      = 1'b0;
        acc_first    = (r_q.st == ST_IDLE) && ready && (rd_req || wr_req) &&
                       (burst_start || r_q.bb);
        acc_next     = (r_q.st == ST_WB2) && ready && wr_req;

        if (acc_first)        r_d.bb = 1'b0;
        else if (burst_start) r_d.bb = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (phy_rst_n && rf_pend) begin
                    take_rf   = 1'b1;
                    r_d.st    = ST_CMD;
                    r_d.op    = OP_RFSH;
                    r_d.addr  = '0;
                    r_d.beats = 2'd1;
                    r_d.cnt   = 2'd1;
                end else if (acc_first) begin
                    r_d.st    = ST_CMD;
                    r_d.addr  = addr;
                    r_d.beats = norm_beats;
                    if (norm_bad) r_d.err = 1'b1;
                    if (rd_req) begin
                        r_d.op  = apch_req ? OP_RDA : OP_RD;
                        r_d.cnt = norm_beats;
                    end else begin
                        r_d.op       = apch_req ? OP_WRA : OP_WR;
                        r_d.cnt      = 2'd1;
                        r_d.wd_valid = 1'b1;
                        r_d.wd_data  = wdata;
                    end
                end
            end
            ST_CMD: begin
                if (cmd_ready)
                    r_d.st = (r_q.cnt != r_q.beats) ? ST_WB2 : ST_IDLE;
            end
            ST_WB2: begin
                if (acc_next) begin
                    r_d.wd_valid = 1'b1;
                    r_d.wd_data  = wdata;
                    r_d.cnt      = r_q.cnt + 1'b1;
                    if (r_d.cnt == r_q.beats) r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.bb       <= 1'b0;
            r_q.op       <= OP_IDLE;
            r_q.addr     <= '0;
            r_q.beats    <= 2'd1;
            r_q.cnt      <= 2'd1;
            r_q.wd_valid <= 1'b0;
            r_q.wd_data  <= '0;
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_valid = (r_q.st == ST_CMD);
    assign cmd_op    = cmd_valid ? r_q.op : OP_IDLE;
    assign cmd_addr  = r_q.addr;
    assign cmd_beats = r_q.beats;
    assign wd_valid  = r_q.wd_valid;
    assign wd_data   = r_q.wd_data;
    assign size_err  = r_q.err;

endmodule

// File: rtl/lreq_frontend_chk.sv
module lreq_frontend_chk #(
    parameter int AW    = 24,
    parameter int RF_CW = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phy_rst_n,
    input logic             ready,
    input logic             rf_req,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [2:0]       cmd_op,
    input logic [AW-1:0]    cmd_addr,
    input logic [1:0]       cmd_beats,
    input logic             size_err,
    input logic [RF_CW-1:0] rf_cnt
);
    localparam logic [RF_CW-1:0] RF_MAX = '1;

    p_phy_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_rst_n |-> (!ready && !cmd_valid));

    p_op_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op >= 3'd1 && cmd_op <= 3'd5));

    p_beats_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_beats == 2'd1 || cmd_beats == 2'd2));

    p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |=> size_err);

    p_rf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_cnt == RF_MAX && rf_req) |=> (rf_cnt >= RF_MAX - 1'b1));

    p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_beats)));

    p_busy_noready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !ready);
endmodule

bind lreq_frontend lreq_frontend_chk #(.AW(AW), .RF_CW(RF_CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phy_rst_n (phy_rst_n),
    .ready     (ready),
    .rf_req    (rf_req),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_beats (cmd_beats),
    .size_err  (size_err),
    .rf_cnt    (rf_cnt)
);

// File: tb/sim_lreq_frontend.sv
module sim_lreq_frontend;
    localparam int CLK_P = 10;
    localparam int AW    = 24;
    localparam int SZW   = 3;
    localparam int LDW   = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0, phy_rst_n = 1'b0;
    logic           burst_start = 0, rd_req = 0, wr_req = 0, apch_req = 0, rf_req = 0;
    logic [AW-1:0]  addr = '0;
    logic [SZW-1:0] size = '0;
    logic [LDW-1:0] wdata = '0;
    logic           ready, cmd_valid, cmd_ready = 1'b1;
    logic [2:0]     cmd_op;
    logic [AW-1:0]  cmd_addr;
    logic [1:0]     cmd_beats;
    logic           wd_valid, size_err;
    logic [LDW-1:0] wd_data;

    int n_chk = 0, n_bad = 0, n_rf = 0, stall_mode = 0;
    int log_op[$];
    int e_op[$], e_beats[$];
    logic [AW-1:0]  e_addr[$];
    logic [LDW-1:0] e_data[$];
    bit fork_done;

    always #(CLK_P/2) clk = ~clk;

    lreq_frontend u0 (
        .clk(clk), .rst_n(rst_n), .phy_rst_n(phy_rst_n), .burst_start(burst_start),
        .rd_req(rd_req), .wr_req(wr_req), .apch_req(apch_req), .rf_req(rf_req),
        .addr(addr), .size(size), .wdata(wdata), .ready(ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_beats(cmd_beats), .wd_valid(wd_valid),
        .wd_data(wd_data), .size_err(size_err)
    );

    function automatic int exp_op(bit wr, bit ap);
        return wr ? (ap ? 4 : 2) : (ap ? 3 : 1);
    endfunction

    function automatic int exp_beats(int sz);
        return (sz >= 2) ? 2 : 1;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // scheduler stall model
    always @(negedge clk) begin
        case (stall_mode)
            0: cmd_ready = 1'b1;
            1: cmd_ready = 1'b0;
            default: cmd_ready = ($urandom % 3) != 0;
        endcase
    end

    // monitor, samples a quarter period before the rising edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (rst_n) begin
            if (cmd_valid && cmd_ready) begin
                log_op.push_back(int'(cmd_op));
                if (cmd_op == 3'd5) n_rf++;
                else if (e_op.size() == 0) check(0, "R3", "unexpected command", cmd_op, 0);
                else begin
                    int eo, eb; logic [AW-1:0] ea;
                    eo = e_op.pop_front(); eb = e_beats.pop_front(); ea = e_addr.pop_front();
                    check(cmd_op == eo, "R3", "cmd_op", cmd_op, eo);
                    check(cmd_addr == ea, "R3", "cmd_addr", cmd_addr, ea);
                    check(cmd_beats == eb, "R4", "cmd_beats", cmd_beats, eb);
                end
            end
            if (wd_valid) begin
                if (e_data.size() == 0) check(0, "R8", "unexpected write beat", wd_data, 0);
                else begin
                    logic [LDW-1:0] ed;
                    ed = e_data.pop_front();
                    check(wd_data == ed, "R8", "wd_data", wd_data, ed);
                end
            end
        end
    end

    // first beat: strobe only in the first cycle, request held until accepted
    task automatic first_beat(bit wr, logic [AW-1:0] a, int sz, bit ap, logic [LDW-1:0] d);
        @(negedge clk);
        rd_req = !wr; wr_req = wr; addr = a; size = SZW'(sz); apch_req = ap;
        wdata = d; burst_start = 1'b1;
        forever begin
            if (ready) begin @(posedge clk); break; end
            @(negedge clk);
            burst_start = 1'b0;
        end
        e_op.push_back(exp_op(wr, ap)); e_beats.push_back(exp_beats(sz)); e_addr.push_back(a);
        if (wr) e_data.push_back(d);
        @(negedge clk);
        burst_start = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
    endtask

    task automatic next_beat(logic [LDW-1:0] d);
        @(negedge clk);
        wr_req = 1'b1; wdata = d;
        forever begin
            if (ready) begin @(posedge clk); break; end
            @(negedge clk);
        end
        e_data.push_back(d);
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic access(bit wr, logic [AW-1:0] a, int sz, bit ap,
                          logic [LDW-1:0] d0, logic [LDW-1:0] d1);
        first_beat(wr, a, sz, ap, d0);
        if (wr && exp_beats(sz) == 2) next_beat(d1);
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (e_op.size() == 0 && e_data.size() == 0 && !cmd_valid) break;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int unsigned seed;
        int base, rf0;
        seed = $urandom(32'h5EED_0042);

        // reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 0, "R1", "ready in reset", ready, 0);
        check(cmd_valid == 0, "R1", "cmd_valid in reset", cmd_valid, 0);
        check(size_err == 0, "R4", "size_err after reset", size_err, 0);

        // R1: requests ignored while PHY held in reset
        rd_req = 1; burst_start = 1; addr = 24'h0000AA; size = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ready == 0, "R1", "ready gated", ready, 0);
            check(cmd_valid == 0, "R1", "no command gated", cmd_valid, 0);
        end
        rd_req = 0; burst_start = 0;
        @(negedge clk);
        phy_rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1, "R1", "ready after release", ready, 1);

        // basic read and 2-beat write with auto-precharge (R3, R8)
        access(0, 24'h001234, 1, 0, '0, '0);
        access(1, 24'h00ABCD, 2, 1, 32'hDEAD0001, 32'hBEEF0002);
        access(0, 24'h000777, 2, 1, '0, '0);
        drain();

        // R4: illegal sizes
        access(0, 24'h000100, 0, 0, '0, '0);
        drain();
        check(size_err == 1, "R4", "size_err after size 0", size_err, 1);
        access(1, 24'h000200, 6, 0, 32'h11112222, 32'h33334444);
        drain();
        check(size_err == 1, "R4", "size_err sticky", size_err, 1);

        // R2: request with no strobe is not accepted
        @(negedge clk);
        rd_req = 1; addr = 24'h000300; size = 1;
        base = log_op.size();
        repeat (5) @(negedge clk);
        check(cmd_valid == 0, "R2", "no accept without strobe", cmd_valid, 0);
        check(log_op.size() == base, "R2", "command count", log_op.size(), base);
        rd_req = 0;

        // R2/R9: strobe seen while ready low is remembered
        stall_mode = 1;
        access(0, 24'h000400, 1, 0, '0, '0);
        fork_done = 0;
        fork begin access(0, 24'h000401, 1, 1, '0, '0); fork_done = 1; end join_none
        repeat (4) @(negedge clk);
        check(ready == 0, "R9", "ready low while command stalled", ready, 0);
        check(cmd_addr == 24'h000400, "R9", "cmd_addr held", cmd_addr, 24'h000400);
        stall_mode = 0;
        wait (fork_done);
        drain();

        // R5/R7: refresh wins, counter saturates at 3
        stall_mode = 1;
        base = log_op.size();
        access(0, 24'h000500, 1, 0, '0, '0);
        @(negedge clk); rf_req = 1;
        repeat (5) @(negedge clk);
        rf_req = 0;
        fork_done = 0;
        fork begin access(1, 24'h000501, 1, 0, 32'hCAFE0000, '0); fork_done = 1; end join_none
        repeat (3) @(negedge clk);
        stall_mode = 0;
        wait (fork_done);
        drain();
        check(log_op.size() == base + 5, "R7", "commands after 5 refresh pulses",
              log_op.size(), base + 5);
        if (log_op.size() == base + 5) begin
            check(log_op[base] == 1, "R5", "slot0", log_op[base], 1);
            for (int i = 1; i < 4; i++)
                check(log_op[base+i] == 5, "R7", "refresh slot", log_op[base+i], 5);
            check(log_op[base+4] == 2, "R5", "write after refreshes", log_op[base+4], 2);
        end

        // R6: refresh waits for second write beat
        rf0 = n_rf;
        first_beat(1, 24'h000600, 2, 0, 32'h60000001);
        repeat (3) @(negedge clk);
        rf_req = 1; @(negedge clk); rf_req = 0;
        repeat (4) @(negedge clk);
        check(n_rf == rf0, "R6", "no refresh mid burst", n_rf, rf0);
        check(ready == 1, "R6", "ready for second beat", ready, 1);
        next_beat(32'h60000002);
        drain();
        check(n_rf == rf0 + 1, "R6", "refresh after burst", n_rf, rf0 + 1);

        // constrained random mix
        stall_mode = 2;
        for (int k = 0; k < 150; k++) begin
            bit wr, ap; int sz;
            wr = $urandom % 2; ap = $urandom % 2; sz = $urandom % 8;
            access(wr, AW'($urandom), sz, ap, $urandom, $urandom);
            if ($urandom % 10 == 0) begin
                rf0 = n_rf;
                @(negedge clk); rf_req = 1; @(negedge clk); rf_req = 0;
                drain();
                check(n_rf == rf0 + 1, "R7", "random refresh issued", n_rf, rf0 + 1);
            end
        end
        stall_mode = 0;
        drain();
        check(e_op.size() == 0, "R3", "all commands seen", e_op.size(), 0);
        check(e_data.size() == 0, "R8", "all beats seen", e_data.size(), 0);
        summary();
    end
endmodule